// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers the event lines of a serial peripheral's FIFO and transfer logic into one level interrupt. Six event inputs cover the receive side (data present, FIFO full, overrun) and the transmit side (FIFO empty, underrun, half empty). Each event lands in a sticky bit of a status register. A per-bit enable register and a single global enable bit decide whether a pending status bit raises the interrupt output.

Software reaches the three registers through a simple word-addressed write port and a combinational read port. A write to the status register XORs the written word into it. Writing a 1 therefore flips the bit, and the same write can clear or set it. An event input is sampled on every clock edge, so a condition that stays high (a receive FIFO that is still non-empty or still full) sets its bit again on every cycle. Such a condition cannot be cleared while it lasts. The output is registered and follows the register state one clock later.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status, enable and global enable registers all read zero and `irq_o` is low.
- R2: The global enable is bit 31 of the word at byte offset 0x1C. The status register is at 0x20 and the enable register at 0x28. Any other offset reads zero, and a write to it changes no register.
- R3: An event input high at a rising clock edge sets its status bit, and the bit stays set until software changes it. The bit positions are: transmit empty 2, transmit underrun 3, receive full 4, receive overrun 5, transmit half empty 6, receive not empty 8.
- R4: A write to the status register replaces each implemented bit with its old value XOR the written bit, so writing 1 clears a set bit and sets a clear bit.
- R5: When an event and a status write land on the same bit in the same cycle, the bit ends up set.
- R6: While an event input is held high, its status bit reads 1 even directly after software has written a 1 to clear it.
- R7: Only the six event positions of the status and enable registers hold state. All other bits of these two registers, and all bits of the global enable word other than bit 31, read zero.
- R8: `irq_o` is high exactly when the global enable is set and some bit is set in both the status and enable registers. It takes its new value one clock after the register state changes.
- R9: With the global enable clear, `irq_o` stays low whatever the status and enable registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| ev_tx_empty | input | 1 | Transmit FIFO empty event |
| ev_tx_underrun | input | 1 | Transmit underrun event |
| ev_rx_full | input | 1 | Receive FIFO full condition |
| ev_rx_overrun | input | 1 | Receive overrun event |
| ev_tx_half | input | 1 | Transmit FIFO half empty event |
| ev_rx_nonempty | input | 1 | Receive FIFO not empty condition |
| irq_o | output | 1 | Registered level interrupt |

## Verification
A wrong status bit shows up on the read port in the first cycle after the edge that stored it. When that bit is enabled and the global enable is set, it also shows on `irq_o` one clock later. The bench sweeps every combination of the six status bits, the six enable bits and the global enable, so a mask or reduction error shows as a wrong interrupt level within that vector. An error in the priority between an event and a software write, or in the re-setting of a held event, shows on the read port in the very next read after the colliding write.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   localparam int unsigned NUM_EV = 6;

   // event order on the internal vector
   typedef enum int unsigned {
      EV_TX_EMPTY    = 0,
      EV_TX_UNDERRUN = 1,
      EV_RX_FULL     = 2,
      EV_RX_OVERRUN  = 3,
      EV_TX_HALF     = 4,
      EV_RX_NONEMPTY = 5
   } ev_idx_e;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_GIE  = 2'd1,
      SEL_ISR  = 2'd2,
      SEL_IER  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/irq_agg_evmap.sv
module irq_agg_evmap #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned EV_POS [irq_agg_pkg::NUM_EV] = '{2, 3, 4, 5, 6, 8}
) (
   input  logic [irq_agg_pkg::NUM_EV-1:0] ev_vec,
   output logic [DATA_W-1:0]              set_vec
);
   import irq_agg_pkg::*;

   function automatic logic [NUM_EV-1:0] sources_of(input int unsigned b);
      logic [NUM_EV-1:0] r;
      r = '0;
      for (int k = 0; k < NUM_EV; k++) begin
         if (EV_POS[k] == b) r[k] = 1'b1;
      end
      return r;
   endfunction

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam logic [NUM_EV-1:0] SRC = sources_of(b);
      if (SRC == '0) begin : g_none
         assign set_vec[b] = 1'b0;
      end else begin : g_src
         assign set_vec[b] = |(ev_vec & SRC);
      end
   end

endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
   parameter int unsigned       DATA_W    = 32,
   parameter logic [DATA_W-1:0] IMPL_MASK = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] set_vec,
   input  logic              tog_en,
   input  logic [DATA_W-1:0] tog_data,
   output logic [DATA_W-1:0] isr_q
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_cell
      if (IMPL_MASK[b]) begin : g_live
         logic bit_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               bit_q <= 1'b0;
            end else begin
               // event set dominates the software toggle
               bit_q <= set_vec[b] | (bit_q ^ (tog_en & tog_data[b]));
            end
         end
         assign isr_q[b] = bit_q;
      end else begin : g_tied
         assign isr_q[b] = 1'b0;
      end
   end

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl #(
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       GIE_BIT   = 31,
   parameter logic [DATA_W-1:0] IMPL_MASK = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              gie_we,
   input  logic              ier_we,
   input  logic [DATA_W-1:0] wdata,
   output logic              gie_q,
   output logic [DATA_W-1:0] ier_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         gie_q <= 1'b0;
      end else if (gie_we) begin
         gie_q <= wdata[GIE_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ier_q <= '0;
      end else if (ier_we) begin
         ier_q <= wdata & IMPL_MASK;
      end
   end

endmodule

// File: rtl/irq_agg_out.sv
module irq_agg_out #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              gie_q,
   input  logic [DATA_W-1:0] isr_q,
   input  logic [DATA_W-1:0] ier_q,
   output logic              irq_o
);

   logic pend;
   assign pend = gie_q & (|(isr_q & ier_q));

   always_ff @(posedge clk) begin
      if (rst) irq_o <= 1'b0;
      else     irq_o <= pend;
   end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
   parameter int unsigned            DATA_W  = 32,
   parameter int unsigned            ADDR_W  = 8,
   parameter logic [ADDR_W-1:0]      GIE_OFS = 8'h1C,
   parameter logic [ADDR_W-1:0]      ISR_OFS = 8'h20,
   parameter logic [ADDR_W-1:0]      IER_OFS = 8'h28,
   parameter int unsigned            GIE_BIT = 31,
   parameter int unsigned            EV_POS [irq_agg_pkg::NUM_EV] = '{2, 3, 4, 5, 6, 8}
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ev_tx_empty,
   input  logic              ev_tx_underrun,
   input  logic              ev_rx_full,
   input  logic              ev_rx_overrun,
   input  logic              ev_tx_half,
   input  logic              ev_rx_nonempty,
   output logic              irq_o
);
   import irq_agg_pkg::*;

   function automatic logic [DATA_W-1:0] mk_mask();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int k = 0; k < NUM_EV; k++) m[EV_POS[k]] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] IMPL_MASK = mk_mask();
   localparam logic [DATA_W-1:0] GIE_MASK  = DATA_W'(1) << GIE_BIT;

   initial begin
      assert (GIE_BIT < DATA_W) else $error("global enable bit outside the data word");
      assert (GIE_OFS[1:0] == 2'b00 && ISR_OFS[1:0] == 2'b00 && IER_OFS[1:0] == 2'b00)
         else $error("register offsets must be word aligned");
      assert (GIE_OFS != ISR_OFS && GIE_OFS != IER_OFS && ISR_OFS != IER_OFS)
         else $error("register offsets must differ");
      for (int k = 0; k < NUM_EV; k++) begin
         assert (EV_POS[k] < DATA_W) else $error("event position outside the data word");
         for (int j = k + 1; j < NUM_EV; j++) begin
            assert (EV_POS[k] != EV_POS[j]) else $error("event positions must differ");
         end
      end
   end

   logic [NUM_EV-1:0] ev_vec;
   assign ev_vec[EV_TX_EMPTY]    = ev_tx_empty;
   assign ev_vec[EV_TX_UNDERRUN] = ev_tx_underrun;
   assign ev_vec[EV_RX_FULL]     = ev_rx_full;
   assign ev_vec[EV_RX_OVERRUN]  = ev_rx_overrun;
   assign ev_vec[EV_TX_HALF]     = ev_tx_half;
   assign ev_vec[EV_RX_NONEMPTY] = ev_rx_nonempty;

   function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
      if (a == GIE_OFS)      return SEL_GIE;
      else if (a == ISR_OFS) return SEL_ISR;
      else if (a == IER_OFS) return SEL_IER;
      else                   return SEL_NONE;
   endfunction

   reg_sel_e wr_sel, rd_sel;
   logic     wr_isr, wr_ier, wr_gie;
   assign wr_sel = decode(wr_addr);
   assign rd_sel = decode(rd_addr);
   assign wr_isr = wr_en && (wr_sel == SEL_ISR);
   assign wr_ier = wr_en && (wr_sel == SEL_IER);
   assign wr_gie = wr_en && (wr_sel == SEL_GIE);

   logic [DATA_W-1:0] set_vec, isr_q, ier_q;
   logic              gie_q;

   irq_agg_evmap #(.DATA_W(DATA_W), .EV_POS(EV_POS)) u_evmap (
      .ev_vec  (ev_vec),
      .set_vec (set_vec)
   );

   irq_agg_status #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_status (
      .clk      (clk),
      .rst      (rst),
      .set_vec  (set_vec),
      .tog_en   (wr_isr),
      .tog_data (wr_data),
      .isr_q    (isr_q)
   );

   irq_agg_ctrl #(.DATA_W(DATA_W), .GIE_BIT(GIE_BIT), .IMPL_MASK(IMPL_MASK)) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .gie_we (wr_gie),
      .ier_we (wr_ier),
      .wdata  (wr_data),
      .gie_q  (gie_q),
      .ier_q  (ier_q)
   );

   irq_agg_out #(.DATA_W(DATA_W)) u_out (
      .clk   (clk),
      .rst   (rst),
      .gie_q (gie_q),
      .isr_q (isr_q),
      .ier_q (ier_q),
      .irq_o (irq_o)
   );

   always_comb begin
      unique case (rd_sel)
         SEL_GIE: rd_data = gie_q ? GIE_MASK : '0;
         SEL_ISR: rd_data = isr_q;
         SEL_IER: rd_data = ier_q;
         default: rd_data = '0;
      endcase
   end

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
   parameter int unsigned       DATA_W    = 32,
   parameter logic [DATA_W-1:0] IMPL_MASK = '0
) (
   input logic              clk,
   input logic              rst,
   input logic              gie_q,
   input logic [DATA_W-1:0] isr_q,
   input logic [DATA_W-1:0] ier_q,
   input logic [DATA_W-1:0] set_vec,
   input logic              wr_isr,
   input logic [DATA_W-1:0] wr_data,
   input logic              irq_o
);

   assert_gie_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      !gie_q |=> !irq_o);

   assert_irq_raise_R8: assert property (@(posedge clk) disable iff (rst)
      (gie_q && (|(isr_q & ier_q))) |=> irq_o);

   assert_irq_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !(|(isr_q & ier_q)) |=> !irq_o);

   // R3 and R5: any event wins over a same-cycle toggle
   assert_event_sticks_R5: assert property (@(posedge clk) disable iff (rst)
      (|set_vec) |=> ((isr_q & $past(set_vec)) == $past(set_vec)));

   assert_toggle_xor_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_isr && set_vec == '0) |=> (isr_q == (($past(isr_q) ^ $past(wr_data)) & IMPL_MASK)));

   assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (rst)
      ((isr_q & ~IMPL_MASK) == '0) && ((ier_q & ~IMPL_MASK) == '0));

endmodule

bind irq_aggregator irq_aggregator_chk #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .gie_q   (gie_q),
   .isr_q   (isr_q),
   .ier_q   (ier_q),
   .set_vec (set_vec),
   .wr_isr  (wr_isr),
   .wr_data (wr_data),
   .irq_o   (irq_o)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;

   localparam logic [7:0] A_GIE = 8'h1C;
   localparam logic [7:0] A_ISR = 8'h20;
   localparam logic [7:0] A_IER = 8'h28;
   localparam int P [6] = '{2, 3, 4, 5, 6, 8};
   localparam logic [31:0] MASK = 32'h0000_017C;

   logic clk = 1'b0, rst = 1'b1;
   logic wr_en = 1'b0;
   logic [7:0] wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0, rd_data;
   logic [5:0] ev = '0;
   logic irq_o;

   int vectors = 0, misses = 0;

   always #4 clk = ~clk;

   irq_aggregator u_irq_aggregator (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .ev_tx_empty(ev[0]), .ev_tx_underrun(ev[1]), .ev_rx_full(ev[2]),
      .ev_rx_overrun(ev[3]), .ev_tx_half(ev[4]), .ev_rx_nonempty(ev[5]),
      .irq_o(irq_o)
   );

   function automatic logic [31:0] expand(input logic [5:0] v);
      logic [31:0] r = '0;
      for (int k = 0; k < 6; k++) r[P[k]] = v[k];
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      misses++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [5:0]  m_isr;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      rd(A_GIE, d); check("R1 gie", d, 0);
      rd(A_ISR, d); check("R1 isr", d, 0);
      rd(A_IER, d); check("R1 ier", d, 0);
      check("R1 irq", {31'b0, irq_o}, 0);

      // R3 capture, sticky; R4 toggle clears
      for (int k = 0; k < 6; k++) begin
         ev[k] = 1'b1; @(negedge clk); ev[k] = 1'b0;
         rd(A_ISR, d); check("R3 capture", d, expand(6'(1) << k));
         @(negedge clk);
         rd(A_ISR, d); check("R3 sticky", d, expand(6'(1) << k));
         wr(A_ISR, expand(6'(1) << k));
         rd(A_ISR, d); check("R4 clear", d, 0);
      end
      // R4 writing 1 to a clear bit sets it
      wr(A_ISR, expand(6'b010010));
      rd(A_ISR, d); check("R4 set", d, expand(6'b010010));
      wr(A_ISR, expand(6'b010011));
      rd(A_ISR, d); check("R4 flip", d, expand(6'b000001));
      wr(A_ISR, expand(6'b000001));

      // R5 event beats a same-cycle toggle
      ev[3] = 1'b1; @(negedge clk);
      wr(A_ISR, expand(6'b001000));
      ev[3] = 1'b0;
      rd(A_ISR, d); check("R5 priority", d, expand(6'b001000));
      wr(A_ISR, expand(6'b001000));
      rd(A_ISR, d); check("R5 clear after", d, 0);

      // R6 held level condition
      ev[2] = 1'b1; ev[5] = 1'b1; @(negedge clk);
      wr(A_ISR, expand(6'b100100));
      rd(A_ISR, d); check("R6 reassert", d, expand(6'b100100));
      ev[2] = 1'b0; ev[5] = 1'b0;
      wr(A_ISR, expand(6'b100100));
      rd(A_ISR, d); check("R6 released", d, 0);

      // R7 unimplemented bits
      wr(A_IER, 32'hFFFF_FFFF);
      rd(A_IER, d); check("R7 ier", d, MASK);
      wr(A_ISR, 32'hFFFF_FFFF);
      rd(A_ISR, d); check("R7 isr", d, MASK);
      wr(A_GIE, 32'h7FFF_FFFF);
      rd(A_GIE, d); check("R7 gie", d, 0);

      // R2 other offsets ignored
      wr(8'h24, 32'hFFFF_FFFF);
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h24, d); check("R2 hole read", d, 0);
      rd(A_ISR, d); check("R2 isr intact", d, MASK);
      rd(A_IER, d); check("R2 ier intact", d, MASK);
      rd(A_GIE, d); check("R2 gie intact", d, 0);
      wr(A_GIE, 32'h8000_0000);
      rd(A_GIE, d); check("R2 gie bit31", d, 32'h8000_0000);
      wr(A_ISR, MASK);

      // R8 latency: state at one edge, output at the next
      wr(A_IER, expand(6'b000001));
      @(negedge clk);
      check("R8 low before", {31'b0, irq_o}, 0);
      wr(A_ISR, expand(6'b000001));
      check("R8 one-cycle lag", {31'b0, irq_o}, 0);
      @(negedge clk);
      check("R8 raised", {31'b0, irq_o}, 1);
      wr(A_ISR, expand(6'b000001));
      m_isr = '0;

      // R8 / R9 exhaustive sweep
      for (int s = 0; s < 64; s++) begin
         for (int e = 0; e < 64; e++) begin
            for (int g = 0; g < 2; g++) begin
               wr(A_ISR, expand(m_isr ^ 6'(s)));
               m_isr = 6'(s);
               wr(A_IER, expand(6'(e)));
               wr(A_GIE, g[0] ? 32'h8000_0000 : 32'h0);
               @(negedge clk);
               check(g[0] ? "R8 sweep" : "R9 sweep", {31'b0, irq_o},
                     {31'b0, g[0] & (|(6'(s) & 6'(e)))});
            end
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule